// File: doc/BRIEF.md
# Mixed-Width Simple Dual-Port RAM

This block is a 4,608-bit on-chip memory with one write port and one read port. Both ports run on a single clock and work in the same cycle. Each port has its own shape, chosen from five depth-by-width options. Because both ports reach the same storage, data written at one width can be read back at another. The block can therefore turn a 4-bit stream into single bits, or pack 9-bit words into 18-bit words.

Storage is two banks of 256 rows, each row nine bits wide. A 9-bit word is one entry of one bank. An 18-bit word is the same row taken across both banks. The 1-, 2- and 4-bit shapes reach only the low eight bits of each 9-bit entry. A narrow element at address `a` of width `w` sits at bit position `a*w` in a byte-addressed view of those low eight bits, least significant slice first.

The shape codes are sampled only while reset is high. They are then held fixed until the next reset. Reset clears the read data register. Reset does not clear the memory contents.

Top module: `mwram`

## Requirements
- R1: Shape code 0 selects 4096x1, 1 selects 2048x2, 2 selects 1024x4, 3 selects 512x9 and 4 selects 256x18. Codes 5, 6 and 7 behave as code 0.
- R2: Each port's shape code is captured on every clock edge where `rst` is high. A change of a shape input while `rst` is low has no effect until the next reset.
- R3: When `rd_en` is high at a clock edge, `rd_data` shows the addressed word after that edge. When `rd_en` is low, `rd_data` holds its last value.
- R4: While `rst` is high, `rd_data` is cleared to zero. Memory contents survive reset.
- R5: The 9-bit word at address `e` is entry `e>>1` of bank `e&1`. The 18-bit word at address `a` places 9-bit word `2a` in bits 8:0 and 9-bit word `2a+1` in bits 17:9.
- R6: A narrow element at address `a` with width `w` (1, 2 or 4) occupies bits `(a*w mod 8)` upward of data byte `floor(a*w/8)`. Data byte `k` is bits 7:0 of 9-bit word `k`. Bit 8 of each 9-bit word is never written through a narrow shape.
- R7: The write shape and the read shape are independent. For example, nibbles written at 1024x4 read back at 4096x1 as a bit stream in address order, least significant bit first.
- R8: A read and a write to the same location in the same cycle return the contents from before the write.
- R9: Write data bits at or above the write width are ignored. Read data bits at or above the read width are zero.
- R10: Address bits at or above the shape's depth are ignored, so such an address wraps onto the low range.
- R11: With `wr_en` low, the memory is not changed, whatever the write address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset; shape codes are sampled while it is high |
| wr_shape_cfg | input | 3 | Write port shape code |
| rd_shape_cfg | input | 3 | Read port shape code |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 12 | Write address in write-shape units |
| wr_data | input | 18 | Write data, LSB-aligned |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 12 | Read address in read-shape units |
| rd_data | output | 18 | Read data, LSB-aligned, valid one cycle after the read |

## Verification
The assertions check four things on every cycle:
- the latched shapes do not move outside reset;
- `rd_data` holds steady when no read is issued;
- a write through any shape other than the 18-bit shape touches exactly one bank;
- a narrow write never reaches the ninth bit of an entry, and read bits above a narrow width stay zero.

The layout can only be shown by the bench scenarios. These write at one shape and read back at another through the full memory, and cover wrap-around addresses, same-cycle read/write collisions, ignored write data bits and shape changes outside reset. A behavioural bit-level model in the bench follows every one of these scenarios.

// File: rtl/mwram_pkg.sv
package mwram_pkg;
    localparam int ROWS      = 256;
    localparam int NBANK     = 2;
    localparam int BYTE_W    = 9;
    localparam int PLAIN_W   = 8;
    localparam int ROW_W     = $clog2(ROWS);
    localparam int ADDR_W    = ROW_W + $clog2(NBANK) + $clog2(PLAIN_W);
    localparam int DATA_W    = NBANK * BYTE_W;

    typedef enum logic [2:0] {
        SHP_X1  = 3'd0,
        SHP_X2  = 3'd1,
        SHP_X4  = 3'd2,
        SHP_X9  = 3'd3,
        SHP_X18 = 3'd4
    } shape_e;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic             bank;
        logic [2:0]       off;
    } loc_t;

    function automatic shape_e decode_shape(input logic [2:0] code);
        case (code)
            3'd1:    return SHP_X2;
            3'd2:    return SHP_X4;
            3'd3:    return SHP_X9;
            3'd4:    return SHP_X18;
            default: return SHP_X1;
        endcase
    endfunction

    function automatic logic is_narrow(input shape_e s);
        return (s != SHP_X9) && (s != SHP_X18);
    endfunction

    function automatic logic [PLAIN_W-1:0] narrow_mask(input shape_e s, input logic [2:0] off);
        logic [PLAIN_W-1:0] m;
        case (s)
            SHP_X4:  m = 8'h0F;
            SHP_X2:  m = 8'h03;
            default: m = 8'h01;
        endcase
        return m << off;
    endfunction

    function automatic loc_t locate(input shape_e s, input logic [ADDR_W-1:0] a);
        loc_t               l;
        logic [ADDR_W-1:0]  ba;
        l = '0;
        case (s)
            SHP_X18: l.row = a[ROW_W-1:0];
            SHP_X9: begin
                l.row  = a[ROW_W:1];
                l.bank = a[0];
            end
            default: begin
                case (s)
                    SHP_X4:  ba = {a[ADDR_W-3:0], 2'b00};
                    SHP_X2:  ba = {a[ADDR_W-2:0], 1'b0};
                    default: ba = a;
                endcase
                l.off  = ba[2:0];
                l.bank = ba[3];
                l.row  = ba[ADDR_W-1:4];
            end
        endcase
        return l;
    endfunction
endpackage

// File: rtl/mwram_bank.sv
module mwram_bank #(
    parameter int ROWS = 256,
    parameter int W    = 9,
    localparam int RW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [RW-1:0] wr_row,
    input  logic [W-1:0]  wr_mask,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    input  logic [RW-1:0] rd_row,
    output logic [W-1:0]  rd_q
);
    logic [W-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wr_row] <= (mem[wr_row] & ~wr_mask) | (wr_data & wr_mask);
        end
    end

    // read-before-write: the non-blocking update leaves the old word visible here
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= mem[rd_row];
        end
    end
endmodule

// File: rtl/mwram_wr_map.sv
module mwram_wr_map
    import mwram_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  shape_e                       shape,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [ROW_W-1:0]             row,
    output logic [NBANK-1:0]             bank_we,
    output logic [NBANK-1:0][BYTE_W-1:0] mask,
    output logic [NBANK-1:0][BYTE_W-1:0] wdata
);
    loc_t loc;

    always_comb begin
        loc     = locate(shape, wr_addr);
        row     = loc.row;
        bank_we = '0;
        mask    = '0;
        wdata   = '0;
        case (shape)
            SHP_X18: begin
                for (int b = 0; b < NBANK; b++) begin
                    bank_we[b] = wr_en;
                    mask[b]    = '1;
                    wdata[b]   = wr_data[b*BYTE_W +: BYTE_W];
                end
            end
            SHP_X9: begin
                bank_we[loc.bank] = wr_en;
                mask[loc.bank]    = '1;
                wdata[loc.bank]   = wr_data[BYTE_W-1:0];
            end
            default: begin
                bank_we[loc.bank] = wr_en;
                mask[loc.bank]    = {1'b0, narrow_mask(shape, loc.off)};
                wdata[loc.bank]   = {1'b0, wr_data[PLAIN_W-1:0] << loc.off};
            end
        endcase
    end

    // R6
    parity_untouched_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_narrow(shape)) |-> (mask[0][BYTE_W-1] == 1'b0 && mask[1][BYTE_W-1] == 1'b0));

    // R5
    single_bank_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && shape != SHP_X18) |-> $onehot(bank_we));
endmodule

// File: rtl/mwram_rd_map.sv
module mwram_rd_map
    import mwram_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  shape_e                       shape,
    input  logic                         rd_en,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [ROW_W-1:0]             row,
    input  logic [NBANK-1:0][BYTE_W-1:0] bank_q,
    output logic [DATA_W-1:0]            rd_data
);
    loc_t               loc;
    logic               bank_q_sel;
    logic [2:0]         off_q;
    logic [PLAIN_W-1:0] slice;

    assign loc = locate(shape, rd_addr);
    assign row = loc.row;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q_sel <= 1'b0;
            off_q      <= '0;
        end else if (rd_en) begin
            bank_q_sel <= loc.bank;
            off_q      <= loc.off;
        end
    end

    always_comb begin
        slice = bank_q[bank_q_sel][PLAIN_W-1:0] >> off_q;
        case (shape)
            SHP_X18: rd_data = {bank_q[1], bank_q[0]};
            SHP_X9:  rd_data = {{(DATA_W-BYTE_W){1'b0}}, bank_q[bank_q_sel]};
            default: rd_data = {{(DATA_W-PLAIN_W){1'b0}}, slice & narrow_mask(shape, 3'd0)};
        endcase
    end
endmodule

// File: rtl/mwram.sv
module mwram
    import mwram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        wr_shape_cfg,
    input  logic [2:0]        rd_shape_cfg,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    shape_e                       wr_shape_q, rd_shape_q;
    logic [ROW_W-1:0]             wr_row, rd_row;
    logic [NBANK-1:0]             bank_we;
    logic [NBANK-1:0][BYTE_W-1:0] wr_mask, wr_wdata, bank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_shape_q <= decode_shape(wr_shape_cfg);
            rd_shape_q <= decode_shape(rd_shape_cfg);
        end
    end

    mwram_wr_map u_wr_map (
        .clk(clk), .rst(rst), .shape(wr_shape_q), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .row(wr_row),
        .bank_we(bank_we), .mask(wr_mask), .wdata(wr_wdata)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        mwram_bank #(.ROWS(ROWS), .W(BYTE_W)) u_bank (
            .clk(clk), .rst(rst), .we(bank_we[b]), .wr_row(wr_row),
            .wr_mask(wr_mask[b]), .wr_data(wr_wdata[b]),
            .rd_en(rd_en), .rd_row(rd_row), .rd_q(bank_q[b])
        );
    end

    mwram_rd_map u_rd_map (
        .clk(clk), .rst(rst), .shape(rd_shape_q), .rd_en(rd_en),
        .rd_addr(rd_addr), .row(rd_row), .bank_q(bank_q), .rd_data(rd_data)
    );

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($stable(wr_shape_q) && $stable(rd_shape_q)));

    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R9
    rd_high_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_shape_q == SHP_X1) |-> (rd_data[DATA_W-1:1] == '0));
endmodule

// File: tb/mwram_bench.sv
module mwram_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  wcfg = 3'd4, rcfg = 3'd4;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0] wa = '0, ra = '0;
    logic [17:0] wd = '0;
    logic [17:0] rd_data;

    int    checks = 0, failures = 0;
    string cur_req = "R4";
    bit    started = 0, done = 0;

    logic        model [4608];
    int          m_ws, m_rs;
    logic [17:0] exp_rd = '0;

    always #5 clk = ~clk;

    mwram u_mwram (
        .clk(clk), .rst(rst), .wr_shape_cfg(wcfg), .rd_shape_cfg(rcfg),
        .wr_en(wr_en), .wr_addr(wa), .wr_data(wd),
        .rd_en(rd_en), .rd_addr(ra), .rd_data(rd_data)
    );

    function automatic int dec(input logic [2:0] c);
        return (c > 3'd4) ? 0 : int'(c);
    endfunction

    function automatic int wid(input int s);
        case (s)
            4: return 18;
            3: return 9;
            2: return 4;
            1: return 2;
            default: return 1;
        endcase
    endfunction

    // bit index of element bit i at address a, in units of (9-bit word * 9 + bit)
    function automatic int bit_at(input int s, input int a, input int i);
        int e, b, ba;
        if (s == 4) begin
            e = 2 * (a % 256) + i / 9;
            b = i % 9;
        end else if (s == 3) begin
            e = a % 512;
            b = i;
        end else begin
            ba = (a * wid(s)) % 4096;
            e  = ba / 8;
            b  = ba % 8 + i;
        end
        return e * 9 + b;
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_ws   = dec(wcfg);
            m_rs   = dec(rcfg);
            exp_rd = '0;
        end else begin
            if (rd_en) begin
                exp_rd = '0;
                for (int i = 0; i < wid(m_rs); i++) exp_rd[i] = model[bit_at(m_rs, int'(ra), i)];
            end
            if (wr_en) begin
                for (int i = 0; i < wid(m_ws); i++) model[bit_at(m_ws, int'(wa), i)] = wd[i];
            end
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (rd_data !== exp_rd) begin
                failures++;
                $display("FAIL %s rd_data actual=%h expected=%h", cur_req, rd_data, exp_rd);
            end
        end
    end

    task automatic step(input logic we, input int a_w, input logic [17:0] d,
                        input logic re, input int a_r);
        @(negedge clk);
        wr_en = we; wa = 12'(a_w); wd = d;
        rd_en = re; ra = 12'(a_r);
    endtask

    task automatic restart(input logic [2:0] ws, input logic [2:0] rs);
        @(negedge clk);
        wr_en = 0; rd_en = 0; rst = 1; wcfg = ws; rcfg = rs;
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (rd_data !== '0) begin
            failures++;
            $display("FAIL R4 reset rd_data actual=%h expected=0", rd_data);
        end
        rst = 0;
    endtask

    task automatic finish_run;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4608; i++) model[i] = 1'b0;
        // R4 and R5: fill the whole array at 256x18, read back
        cur_req = "R4";
        restart(3'd4, 3'd4);
        cur_req = "R5";
        for (int a = 0; a < 256; a++) step(1, a, 18'(a * 1031 + 77), 0, 0);
        for (int a = 0; a < 256; a += 7) step(0, 0, 0, 1, a);
        // R10: address beyond depth wraps
        cur_req = "R10";
        step(0, 0, 0, 1, 256 + 3);
        step(0, 0, 0, 1, 4095);
        // R8: same-cycle collision returns old data
        cur_req = "R8";
        step(1, 9, 18'h2AAAA, 1, 9);
        step(0, 0, 0, 1, 9);
        // R3: rd_data holds with rd_en low while address moves
        cur_req = "R3";
        step(0, 0, 0, 1, 40);
        for (int k = 0; k < 5; k++) step(0, 0, 0, 0, k * 13);
        // R11: wr_en low leaves memory intact
        cur_req = "R11";
        for (int k = 0; k < 6; k++) step(0, 40 + k, 18'h3FFFF, 0, 0);
        step(0, 0, 0, 1, 40);
        step(0, 0, 0, 1, 43);
        // R2: shape inputs change outside reset without effect
        cur_req = "R2";
        step(0, 0, 0, 0, 0);
        wcfg = 3'd0; rcfg = 3'd0;
        step(1, 77, 18'h15A5A, 0, 0);
        step(0, 0, 0, 1, 77);
        step(0, 0, 0, 1, 76);
        // R5: 512x9 write, 256x18 read
        cur_req = "R5";
        restart(3'd3, 3'd4);
        for (int a = 20; a < 30; a++) step(1, a, 18'(a * 97 + 256), 0, 0);
        for (int a = 10; a < 15; a++) step(0, 0, 0, 1, a);
        // R8 at 9-bit shape
        cur_req = "R8";
        restart(3'd3, 3'd3);
        step(1, 300, 18'h1C3, 1, 300);
        step(0, 0, 0, 1, 300);
        // R7, R9, R10: 1024x4 write with junk high bits, read as 4096x1 stream
        cur_req = "R7";
        restart(3'd2, 3'd0);
        for (int a = 0; a < 16; a++) step(1, a, 18'((a * 5 + 3) | 18'h3FFF0), 0, 0);
        step(1, 1024 + 20, 18'h0000B, 0, 0);
        for (int a = 0; a < 64; a++) step(0, 0, 0, 1, a);
        cur_req = "R10";
        for (int a = 80; a < 84; a++) step(0, 0, 0, 1, a);
        cur_req = "R9";
        restart(3'd2, 3'd2);
        for (int a = 0; a < 16; a++) step(0, 0, 0, 1, a);
        // R6: 4096x1 writes read as 1024x4, and 2048x2 zeros keep the ninth bit
        cur_req = "R6";
        restart(3'd0, 3'd2);
        for (int a = 200; a < 240; a++) step(1, a, 18'(a % 3 == 0), 0, 0);
        for (int a = 50; a < 60; a++) step(0, 0, 0, 1, a);
        restart(3'd3, 3'd3);
        for (int a = 100; a < 104; a++) step(1, a, 18'h1FF, 0, 0);
        restart(3'd1, 3'd3);
        for (int a = 400; a < 416; a++) step(1, a, 18'h0, 0, 0);
        for (int a = 100; a < 104; a++) step(0, 0, 0, 1, a);
        // R1: invalid codes act as single-bit shape
        cur_req = "R1";
        restart(3'd7, 3'd6);
        for (int a = 3000; a < 3016; a++) step(1, a, 18'(a & 1), 0, 0);
        for (int a = 3000; a < 3016; a++) step(0, 0, 0, 1, a);
        restart(3'd1, 3'd4);
        step(1, 5, 18'h3, 0, 0);
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        finish_run();
    end
endmodule